// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block gathers the four interrupt causes of a UART and presents the most urgent pending one through an 8-bit read-only identification value and a single interrupt request line. The four causes are a receive line status condition, receive data available, an empty transmit holding register, and a change of modem status. Each cause is held in its own pending flag. A flag clears through the register access that services it. The block receives these accesses as one-cycle strobes from the bus decoder, which sits outside the block.

The transmit-empty cause sets on the rising edge of its condition. The other three causes set whenever their condition is high, and setting wins over a same-cycle clear. A read of the identification value while it reports transmit-empty is destructive and drops that cause. Per-cause enables mask what is reported. They do not stop a flag from latching, so a masked cause appears as soon as it is enabled.

Top module: `uart_int_ident`

## Requirements
- R1: With `rst` high at a clock edge, all pending flags clear; after that edge `ident_o` reads 0x01 and `irq_o` is 0.
- R2: Bits 7:3 of `ident_o` always read 0.
- R3: Bit 0 of `ident_o` is 0 when an enabled cause is pending and 1 when none is; `irq_o` is always the inverse of bit 0.
- R4: Bits 2:1 of `ident_o` carry the cause code: 00 modem status, 01 transmit holding empty, 10 receive data ready, 11 line status. When several enabled causes are pending, the highest code is reported.
- R5: A `rd_line_stat` strobe clears the line status flag, unless `line_cond` is high in the same cycle.
- R6: A `rd_rx_buf` strobe clears the receive data flag, unless `rxdat_cond` is high in the same cycle.
- R7: A `rd_modem_stat` strobe clears the modem status flag, unless `modem_cond` is high in the same cycle.
- R8: A `wr_tx_hold` strobe clears the transmit-empty flag.
- R9: A `rd_ident` strobe clears the transmit-empty flag only if `ident_o` reports code 01 with bit 0 low in that cycle. It has no effect while another cause is reported.
- R10: The transmit-empty flag sets only on a 0-to-1 transition of `thr_empty`, so holding `thr_empty` high does not raise it again after a clear. A rising edge in the same cycle as a clear leaves the flag set.
- R11: The line status, receive data and modem flags set whenever their condition input is high at a clock edge.
- R12: `src_en` bit n enables the cause with code n. A disabled cause still latches, is not reported, and is reported as soon as its enable bit is set.
- R13: A clear strobe affects only its own cause's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_cond | input | 1 | Receive line status condition |
| rxdat_cond | input | 1 | Receive data available condition |
| thr_empty | input | 1 | Transmit holding register empty level |
| modem_cond | input | 1 | Modem status change condition |
| src_en | input | 4 | Per-cause enable, bit index equals cause code |
| rd_line_stat | input | 1 | Strobe: line status register read |
| rd_rx_buf | input | 1 | Strobe: receive buffer read |
| rd_ident | input | 1 | Strobe: identification register read |
| rd_modem_stat | input | 1 | Strobe: modem status register read |
| wr_tx_hold | input | 1 | Strobe: transmit holding register write |
| ident_o | output | 8 | Identification register value |
| irq_o | output | 1 | Interrupt request, high while an enabled cause is pending |

## Verification
A flag that sticks or is lost shows on `ident_o` in the cycle after the strobe or edge that should have changed it. A cause that should have dropped stays in bits 2:1, or a lower cause that should have appeared is hidden. The sequence checks every flag transition one cycle later. It steps the reported cause down through the priority order so that each lower flag becomes visible in turn. An edge detector that wrongly re-arms the transmit-empty cause shows up when the identification value returns to 0x02 while `thr_empty` is held high.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NUM_SRC = 4;
    localparam int IDR_W   = 8;
    localparam int CODE_W  = 2;

    // Cause code equals priority rank: larger code wins.
    typedef enum logic [CODE_W-1:0] {
        CAUSE_MODEM = 2'b00,
        CAUSE_THRE  = 2'b01,
        CAUSE_RXRDY = 2'b10,
        CAUSE_LINE  = 2'b11
    } cause_e;

    typedef struct packed {
        logic rd_line;
        logic rd_rx;
        logic rd_ident;
        logic rd_modem;
        logic wr_thr;
    } access_s;

    typedef struct packed {
        logic   valid;
        cause_e cause;
    } report_s;

    function automatic report_s pick_top(input logic [NUM_SRC-1:0] req);
        report_s r;
        r.valid = 1'b0;
        r.cause = CAUSE_MODEM;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i]) begin
                r.valid = 1'b1;
                r.cause = cause_e'(i[CODE_W-1:0]);
            end
        end
        return r;
    endfunction

    function automatic logic [IDR_W-1:0] pack_ident(input report_s r);
        logic [IDR_W-1:0] v;
        v = '0;
        v[0] = ~r.valid;
        v[CODE_W:1] = r.cause;
        return v;
    endfunction

endpackage

// File: rtl/uirq_src.sv
module uirq_src #(
    parameter bit EDGE_SET = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    input  logic clr,
    output logic pending
);

    logic set_now;

    generate
        if (EDGE_SET) begin : g_edge
            logic cond_q;
            always_ff @(posedge clk) begin
                if (rst) cond_q <= 1'b0;
                else     cond_q <= cond;
            end
            assign set_now = cond & ~cond_q;
        end else begin : g_level
            assign set_now = cond;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)          pending <= 1'b0;
        else if (set_now) pending <= 1'b1;
        else if (clr)     pending <= 1'b0;
    end

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  logic [NUM_SRC-1:0] pending,
    input  logic [NUM_SRC-1:0] enable,
    output report_s            report
);

    always_comb begin
        report = pick_top(pending & enable);
    end

endmodule

// File: rtl/uirq_clr_map.sv
module uirq_clr_map
    import uirq_pkg::*;
(
    input  access_s            acc,
    input  report_s            report,
    output logic [NUM_SRC-1:0] clr
);

    logic ident_hits_thre;

    always_comb begin
        ident_hits_thre  = acc.rd_ident & report.valid & (report.cause == CAUSE_THRE);
        clr              = '0;
        clr[CAUSE_MODEM] = acc.rd_modem;
        clr[CAUSE_THRE]  = acc.wr_thr | ident_hits_thre;
        clr[CAUSE_RXRDY] = acc.rd_rx;
        clr[CAUSE_LINE]  = acc.rd_line;
    end

endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
    import uirq_pkg::*;
#(
    parameter logic [NUM_SRC-1:0] EDGE_MASK = 4'b0010
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_cond,
    input  logic               rxdat_cond,
    input  logic               thr_empty,
    input  logic               modem_cond,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               rd_line_stat,
    input  logic               rd_rx_buf,
    input  logic               rd_ident,
    input  logic               rd_modem_stat,
    input  logic               wr_tx_hold,
    output logic [IDR_W-1:0]   ident_o,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] cond_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] pend_vec;
    access_s            acc;
    report_s            report;

    always_comb begin
        cond_vec              = '0;
        cond_vec[CAUSE_MODEM] = modem_cond;
        cond_vec[CAUSE_THRE]  = thr_empty;
        cond_vec[CAUSE_RXRDY] = rxdat_cond;
        cond_vec[CAUSE_LINE]  = line_cond;
        acc.rd_line  = rd_line_stat;
        acc.rd_rx    = rd_rx_buf;
        acc.rd_ident = rd_ident;
        acc.rd_modem = rd_modem_stat;
        acc.wr_thr   = wr_tx_hold;
    end

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            uirq_src #(.EDGE_SET(EDGE_MASK[i])) u_src (
                .clk     (clk),
                .rst     (rst),
                .cond    (cond_vec[i]),
                .clr     (clr_vec[i]),
                .pending (pend_vec[i])
            );
        end
    endgenerate

    uirq_prio u_prio (
        .pending (pend_vec),
        .enable  (src_en),
        .report  (report)
    );

    uirq_clr_map u_clr (
        .acc    (acc),
        .report (report),
        .clr    (clr_vec)
    );

    assign ident_o = pack_ident(report);
    assign irq_o   = report.valid;

endmodule

// File: rtl/uirq_chk.sv
module uirq_chk
    import uirq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             line_cond,
    input logic             rxdat_cond,
    input logic             thr_empty,
    input logic             modem_cond,
    input logic             rd_line_stat,
    input logic             rd_rx_buf,
    input logic             rd_ident,
    input logic             rd_modem_stat,
    input logic             wr_tx_hold,
    input logic [IDR_W-1:0] ident_o,
    input logic             irq_o
);

    logic thr_seen;
    logic thr_rise;

    always_ff @(posedge clk) begin
        if (rst) thr_seen <= 1'b0;
        else     thr_seen <= thr_empty;
    end
    assign thr_rise = thr_empty & ~thr_seen;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (ident_o == 8'h01 && !irq_o));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        ident_o[IDR_W-1:3] == '0);

    assert_irq_inverse_R3: assert property (@(posedge clk) disable iff (rst)
        irq_o == !ident_o[0]);

    assert_line_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_line_stat && !line_cond) |=> (ident_o[2:0] != 3'b110));

    assert_rx_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_rx_buf && !rxdat_cond) |=> (ident_o[2:0] != 3'b100));

    assert_modem_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_modem_stat && !modem_cond) |=> (ident_o[2:0] != 3'b000));

    assert_thr_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_tx_hold && !thr_rise) |=> (ident_o[2:0] != 3'b010));

    assert_ident_read_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_ident && ident_o[2:0] == 3'b010 && !thr_rise) |=> (ident_o[2:0] != 3'b010));

endmodule

bind uart_int_ident uirq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .line_cond     (line_cond),
    .rxdat_cond    (rxdat_cond),
    .thr_empty     (thr_empty),
    .modem_cond    (modem_cond),
    .rd_line_stat  (rd_line_stat),
    .rd_rx_buf     (rd_rx_buf),
    .rd_ident      (rd_ident),
    .rd_modem_stat (rd_modem_stat),
    .wr_tx_hold    (wr_tx_hold),
    .ident_o       (ident_o),
    .irq_o         (irq_o)
);

// File: tb/sim_uart_int_ident.sv
module sim_uart_int_ident;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_cond = 1'b0, rxdat_cond = 1'b0, thr_empty = 1'b0, modem_cond = 1'b0;
    logic [3:0] src_en = 4'hF;
    logic       rd_line_stat = 1'b0, rd_rx_buf = 1'b0, rd_ident = 1'b0;
    logic       rd_modem_stat = 1'b0, wr_tx_hold = 1'b0;
    logic [7:0] ident_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #2 clk = ~clk;

    uart_int_ident u0 (
        .clk(clk), .rst(rst),
        .line_cond(line_cond), .rxdat_cond(rxdat_cond),
        .thr_empty(thr_empty), .modem_cond(modem_cond),
        .src_en(src_en),
        .rd_line_stat(rd_line_stat), .rd_rx_buf(rd_rx_buf), .rd_ident(rd_ident),
        .rd_modem_stat(rd_modem_stat), .wr_tx_hold(wr_tx_hold),
        .ident_o(ident_o), .irq_o(irq_o)
    );

    // cond bits: [3] line, [2] rx data, [1] thr empty, [0] modem
    // acc bits:  [4] rd line, [3] rd rx buf, [2] rd ident, [1] rd modem, [0] wr thr
    task automatic tick(input logic r, input logic [3:0] c, input logic [3:0] en,
                        input logic [4:0] acc, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rst = r;
        {line_cond, rxdat_cond, thr_empty, modem_cond} = c;
        src_en = en;
        {rd_line_stat, rd_rx_buf, rd_ident, rd_modem_stat, wr_tx_hold} = acc;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // Monitor: compare after each rising edge
    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            logic [7:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(ident_o == e, t, ident_o, e);
            check(irq_o == !e[0], {t, " R3 irq"}, {7'b0, irq_o}, {7'b0, !e[0]});
            check(ident_o[7:3] == 5'b0, {t, " R2 upper"}, {3'b0, ident_o[7:3]}, 8'h00);
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        tick(1, 4'b0000, 4'hF, 5'b00000, 8'h01, "R1 reset");
        tick(1, 4'b0000, 4'hF, 5'b00000, 8'h01, "R1 reset");
        tick(0, 4'b0000, 4'hF, 5'b00000, 8'h01, "R3 idle");
        tick(0, 4'b0001, 4'hF, 5'b00000, 8'h00, "R4 modem");
        tick(0, 4'b0010, 4'hF, 5'b00000, 8'h02, "R4 thr over modem");
        tick(0, 4'b0110, 4'hF, 5'b00000, 8'h04, "R4 rx over thr");
        tick(0, 4'b1110, 4'hF, 5'b00000, 8'h06, "R4 line top");
        tick(0, 4'b0110, 4'hF, 5'b10000, 8'h04, "R5 line read");
        tick(0, 4'b0110, 4'hF, 5'b01000, 8'h04, "R11 rx cond held");
        tick(0, 4'b0010, 4'hF, 5'b01000, 8'h02, "R6 rx read");
        tick(0, 4'b0010, 4'hF, 5'b00100, 8'h00, "R9 ident read");
        tick(0, 4'b0010, 4'hF, 5'b00000, 8'h00, "R10 level held");
        tick(0, 4'b0010, 4'hF, 5'b00010, 8'h01, "R7 modem read");
        tick(0, 4'b0000, 4'hF, 5'b00000, 8'h01, "R10 fall");
        tick(0, 4'b0010, 4'hF, 5'b00000, 8'h02, "R10 rise");
        tick(0, 4'b0010, 4'hF, 5'b00001, 8'h01, "R8 thr write");
        tick(0, 4'b0000, 4'hD, 5'b00000, 8'h01, "R12 prep");
        tick(0, 4'b0010, 4'hD, 5'b00000, 8'h01, "R12 masked");
        tick(0, 4'b0010, 4'hF, 5'b00000, 8'h02, "R12 unmask");
        tick(0, 4'b0011, 4'hF, 5'b00000, 8'h02, "R4 thr keeps lead");
        tick(0, 4'b0110, 4'hF, 5'b00000, 8'h04, "R11 rx set");
        tick(0, 4'b0010, 4'hF, 5'b00100, 8'h04, "R9 other cause");
        tick(0, 4'b0010, 4'hF, 5'b01000, 8'h02, "R13 thr kept");
        tick(0, 4'b0010, 4'hF, 5'b00001, 8'h00, "R13 modem kept");
        tick(0, 4'b0010, 4'hF, 5'b00010, 8'h01, "R7 modem read");
        tick(0, 4'b0000, 4'hF, 5'b11111, 8'h01, "R13 idle strobes");
        tick(0, 4'b0010, 4'hF, 5'b00001, 8'h02, "R10 set wins");
        tick(0, 4'b1010, 4'h0, 5'b00000, 8'h01, "R12 all masked");
        tick(1, 4'b0000, 4'hF, 5'b00000, 8'h01, "R1 reset clears");
        tick(0, 4'b0000, 4'hF, 5'b00000, 8'h01, "R1 after reset");
        @(negedge clk);
        @(negedge clk);
        if (q_exp.size() != 0) begin
            errors++;
            $display("FAIL queue actual=%0d expected=0", q_exp.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule